// File: doc/BRIEF.md
# Four-Bank CAN Receive Acceptance Filter

This block decides, for every CAN frame the receiver has finished, whether that frame goes into the receive FIFO. It holds four independent filter banks. Each bank has a compare pattern, a don't-care mask, a format selector (standard or extended) and an enable bit. A frame passes when at least one enabled bank matches both its identifier and its remote-request bit. The result is registered and comes out as a one-cycle accept pulse, together with a vector that shows which banks hit.

A write-only configuration port lets the host reprogram a bank while traffic flows. Writing a bank's pattern or mask disables that bank. The bank comes back into use only when its control word is written, which acts as the update-complete write. A bank that is only partly rewritten therefore cannot produce a false accept, and the other banks keep deciding as before.

Top module: `can_accept_filter`

## Requirements
- R1: After reset `accept` and `hitVec` are 0 and every bank is disabled, so no frame is accepted until a bank is configured.
- R2: The decision appears on `accept`/`hitVec` in the clock cycle after the one in which `frmDone` is high, and lasts one cycle; while `frmDone` is low, both outputs read 0 in the following cycle.
- R3: A bank in standard format compares only `frmId[10:0]` and `frmRtr`; `frmId[28:11]` has no effect on it.
- R4: A bank in standard format never hits a frame with `frmIde`=1, even when its mask makes every bit don't-care.
- R5: A bank in extended format compares all 29 bits of `frmId` and `frmRtr`, and never hits a frame with `frmIde`=0.
- R6: A mask bit of 1 makes the matching position don't-care: mask bits 28:0 cover identifier bits 28:0, and mask bit 29 covers the RTR bit.
- R7: `hitVec[i]` is 1 exactly when bank i matched, and `accept` is the OR of those hits.
- R8: Writing the pattern or the mask of a bank disables that bank until its control word is written. The decisions of the other banks do not change.
- R9: Register map: `cfgAddr[3:2]` selects the bank and `cfgAddr[1:0]` selects the register. 0 is the pattern, 1 is the mask, and both place identifier bits in 28:0 and RTR in bit 29. 2 is the control word, with bit 0 as enable and bit 1 as extended format (1) or standard (0). 3 is a reserved register, and writes to it have no effect.
- R10: A configuration write in the same cycle as `frmDone` does not affect that frame's decision. The configuration in place before the write is used.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| frmId | input | 29 | Received identifier; a standard frame uses bits 10:0 |
| frmIde | input | 1 | 1 for an extended-format frame |
| frmRtr | input | 1 | Remote transmission request bit of the frame |
| frmDone | input | 1 | One-cycle strobe: frame complete, evaluate now |
| cfgWe | input | 1 | Configuration write enable |
| cfgAddr | input | 4 | Bank (3:2) and register (1:0) select |
| cfgWdata | input | 32 | Configuration write data |
| accept | output | 1 | One-cycle pulse: frame goes to the FIFO |
| hitVec | output | 4 | Per-bank hit flags for the decided frame |

## Verification
The checker keeps its own copy of each bank's format and pending-update state, built from the writes it sees on the configuration port. It assumes that `frmIde`, `frmDone`, `cfgWe`, `cfgAddr` and `cfgWdata` are never X while out of reset, and that all configuration goes through this port. The directed bench drives these inputs at the falling edge, holds them at known values between operations, and sets every bank through complete pattern, mask and control writes. The bench computes every expected hit vector by hand from the programmed patterns.

// File: rtl/can_filt_pkg.sv
package can_filt_pkg;
  parameter int NUM_BANKS = 4;
  parameter int ID_W      = 29;
  parameter int STD_W     = 11;
  parameter int DATA_W    = 32;
  localparam int BANK_W   = $clog2(NUM_BANKS);
  localparam int ADDR_W   = BANK_W + 2;

  typedef enum logic [1:0] {
    REG_CODE = 2'd0,
    REG_MASK = 2'd1,
    REG_CTL  = 2'd2,
    REG_RSVD = 2'd3
  } regSel_e;

  typedef struct packed {
    logic [NUM_BANKS-1:0] codeWr;
    logic [NUM_BANKS-1:0] maskWr;
    logic [NUM_BANKS-1:0] ctlWr;
    logic                 evalNow;
  } filtStrobes_t;
endpackage

// File: rtl/can_filt_ctrl.sv
module can_filt_ctrl
  import can_filt_pkg::*;
(
  input  logic              cfgWe,
  input  logic [ADDR_W-1:0] cfgAddr,
  input  logic              frmDone,
  output filtStrobes_t      strobes
);
  logic [BANK_W-1:0] bankSel;
  regSel_e           regSel;

  assign bankSel = cfgAddr[ADDR_W-1:2];
  assign regSel  = regSel_e'(cfgAddr[1:0]);

  always_comb begin
    strobes         = '0;
    strobes.evalNow = frmDone;
    if (cfgWe) begin
      unique case (regSel)
        REG_CODE: strobes.codeWr[bankSel] = 1'b1;
        REG_MASK: strobes.maskWr[bankSel] = 1'b1;
        REG_CTL:  strobes.ctlWr[bankSel]  = 1'b1;
        default:  ;
      endcase
    end
  end
endmodule

// File: rtl/can_filt_datapath.sv
module can_filt_datapath
  import can_filt_pkg::*;
(
  input  logic                 clk,
  input  logic                 rstN,
  input  filtStrobes_t         strobes,
  input  logic [DATA_W-1:0]    cfgWdata,
  input  logic [ID_W-1:0]      frmId,
  input  logic                 frmIde,
  input  logic                 frmRtr,
  output logic                 accept,
  output logic [NUM_BANKS-1:0] hitVec
);
  localparam logic [ID_W:0] STD_CARE =
    {1'b1, {(ID_W-STD_W){1'b0}}, {STD_W{1'b1}}};

  logic [ID_W:0]          frameVec;
  logic [NUM_BANKS-1:0]   bankHit;

  assign frameVec = {frmRtr, frmId};

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    logic [ID_W:0] codeQ;
    logic [ID_W:0] maskQ;
    logic          enQ;
    logic          extQ;
    logic [ID_W:0] diff;

    always_ff @(posedge clk) begin
      if (!rstN) begin
        codeQ <= '0;
        maskQ <= '0;
        enQ   <= 1'b0;
        extQ  <= 1'b0;
      end else begin
        if (strobes.codeWr[b]) begin
          codeQ <= cfgWdata[ID_W:0];
          enQ   <= 1'b0;
        end
        if (strobes.maskWr[b]) begin
          maskQ <= cfgWdata[ID_W:0];
          enQ   <= 1'b0;
        end
        if (strobes.ctlWr[b]) begin
          enQ  <= cfgWdata[0];
          extQ <= cfgWdata[1];
        end
      end
    end

    assign diff = (codeQ ^ frameVec) & ~maskQ;

    always_comb begin
      if (!enQ)      bankHit[b] = 1'b0;
      else if (extQ) bankHit[b] = frmIde && (diff == '0);
      else           bankHit[b] = !frmIde && ((diff & STD_CARE) == '0);
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      accept <= 1'b0;
      hitVec <= '0;
    end else begin
      accept <= strobes.evalNow && (|bankHit);
      hitVec <= strobes.evalNow ? bankHit : '0;
    end
  end
endmodule

// File: rtl/can_accept_filter.sv
module can_accept_filter
  import can_filt_pkg::*;
(
  input  logic                 clk,
  input  logic                 rstN,
  input  logic [ID_W-1:0]      frmId,
  input  logic                 frmIde,
  input  logic                 frmRtr,
  input  logic                 frmDone,
  input  logic                 cfgWe,
  input  logic [ADDR_W-1:0]    cfgAddr,
  input  logic [DATA_W-1:0]    cfgWdata,
  output logic                 accept,
  output logic [NUM_BANKS-1:0] hitVec
);
  filtStrobes_t strobes;

  can_filt_ctrl u_ctrl (
    .cfgWe   (cfgWe),
    .cfgAddr (cfgAddr),
    .frmDone (frmDone),
    .strobes (strobes)
  );

  can_filt_datapath u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .strobes  (strobes),
    .cfgWdata (cfgWdata),
    .frmId    (frmId),
    .frmIde   (frmIde),
    .frmRtr   (frmRtr),
    .accept   (accept),
    .hitVec   (hitVec)
  );
endmodule

// File: rtl/can_accept_filter_chk.sv
module can_accept_filter_chk
  import can_filt_pkg::*;
(
  input logic                 clk,
  input logic                 rstN,
  input logic                 frmIde,
  input logic                 frmDone,
  input logic                 cfgWe,
  input logic [ADDR_W-1:0]    cfgAddr,
  input logic [DATA_W-1:0]    cfgWdata,
  input logic                 accept,
  input logic [NUM_BANKS-1:0] hitVec
);
  logic [NUM_BANKS-1:0] pendMirror;
  logic [NUM_BANKS-1:0] extMirror;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      pendMirror <= '0;
      extMirror  <= '0;
    end else if (cfgWe) begin
      if (cfgAddr[1:0] == 2'd2) begin
        pendMirror[cfgAddr[ADDR_W-1:2]] <= 1'b0;
        extMirror[cfgAddr[ADDR_W-1:2]]  <= cfgWdata[1];
      end else if (cfgAddr[1:0] != 2'd3) begin
        pendMirror[cfgAddr[ADDR_W-1:2]] <= 1'b1;
      end
    end
  end

  // R2: no strobe, no decision in the next cycle
  a_r2_idle_quiet: assert property (@(posedge clk) disable iff (!rstN)
    !frmDone |=> (!accept && hitVec == '0));

  // R7: accept agrees with the per-bank hits
  a_r7_or_of_hits: assert property (@(posedge clk) disable iff (!rstN)
    accept == (|hitVec));

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_chk
    // R8: a bank with an unfinished update never hits
    a_r8_pending_blocks: assert property (@(posedge clk) disable iff (!rstN)
      (frmDone && pendMirror[b]) |=> !hitVec[b]);
    // R4: a standard-format bank ignores extended frames
    a_r4_std_no_ext: assert property (@(posedge clk) disable iff (!rstN)
      (frmDone && frmIde && !extMirror[b]) |=> !hitVec[b]);
    // R5: an extended-format bank ignores standard frames
    a_r5_ext_no_std: assert property (@(posedge clk) disable iff (!rstN)
      (frmDone && !frmIde && extMirror[b]) |=> !hitVec[b]);
  end
endmodule

bind can_accept_filter can_accept_filter_chk u_chk (.*);

// File: tb/can_accept_filter_bench.sv
module can_accept_filter_bench;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [28:0] frmId = '0;
  logic        frmIde = 1'b0;
  logic        frmRtr = 1'b0;
  logic        frmDone = 1'b0;
  logic        cfgWe = 1'b0;
  logic [3:0]  cfgAddr = '0;
  logic [31:0] cfgWdata = '0;
  logic        accept;
  logic [3:0]  hitVec;

  int  vectors = 0;
  int  miscompares = 0;
  bit  finished = 1'b0;

  always #2 clk = ~clk;

  can_accept_filter u_can_accept_filter (
    .clk(clk), .rstN(rstN), .frmId(frmId), .frmIde(frmIde), .frmRtr(frmRtr),
    .frmDone(frmDone), .cfgWe(cfgWe), .cfgAddr(cfgAddr), .cfgWdata(cfgWdata),
    .accept(accept), .hitVec(hitVec)
  );

  task automatic chk(string tag, logic [31:0] got, logic [31:0] exp);
    vectors++;
    if (got !== exp) begin
      miscompares++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic wr(int bank, int sel, logic [31:0] d);
    @(negedge clk);
    cfgWe = 1'b1; cfgAddr = {bank[1:0], sel[1:0]}; cfgWdata = d;
    @(negedge clk);
    cfgWe = 1'b0; cfgAddr = '0; cfgWdata = '0;
  endtask

  // present one frame; optionally a config write in the same cycle
  task automatic frame(string tag, logic [28:0] id, logic ide, logic rtr,
                       logic [3:0] exp, bit withWr = 0, int wb = 0,
                       int ws = 0, logic [31:0] wd = '0);
    @(negedge clk);
    frmId = id; frmIde = ide; frmRtr = rtr; frmDone = 1'b1;
    if (withWr) begin
      cfgWe = 1'b1; cfgAddr = {wb[1:0], ws[1:0]}; cfgWdata = wd;
    end
    @(negedge clk);
    frmDone = 1'b0; cfgWe = 1'b0; cfgAddr = '0; cfgWdata = '0;
    chk({tag, " hitVec"}, {28'd0, hitVec}, {28'd0, exp});
    chk({tag, " accept"}, {31'd0, accept}, {31'd0, (exp != 4'd0)});
  endtask

  task automatic t_reset();
    chk("R1 reset accept", {31'd0, accept}, 32'd0);
    chk("R1 reset hitVec", {28'd0, hitVec}, 32'd0);
    frame("R1 no bank enabled", 29'h0, 1'b0, 1'b0, 4'b0000);
    frame("R1 no bank enabled ext", 29'h1FFFFFFF, 1'b1, 1'b1, 4'b0000);
  endtask

  task automatic t_std();
    wr(0, 0, 32'h0000_0123);
    wr(0, 1, 32'h0);
    wr(0, 2, 32'h1);               // enable, standard
    frame("R3 std exact", 29'h123, 1'b0, 1'b0, 4'b0001);
    @(negedge clk);
    chk("R2 single pulse", {31'd0, accept}, 32'd0);
    chk("R2 idle hitVec", {28'd0, hitVec}, 32'd0);
    frame("R3 upper bits ignored", {18'h2ABCD, 11'h123}, 1'b0, 1'b0, 4'b0001);
    frame("R3 id mismatch", 29'h124, 1'b0, 1'b0, 4'b0000);
    frame("R3 rtr mismatch", 29'h123, 1'b0, 1'b1, 4'b0000);
    frame("R4 ext frame to std bank", 29'h123, 1'b1, 1'b0, 4'b0000);
  endtask

  task automatic t_ext();
    wr(1, 0, 32'h1ABC_DE12);
    wr(1, 1, 32'h0);
    wr(1, 2, 32'h3);               // enable, extended
    frame("R5 ext exact", 29'h1ABCDE12, 1'b1, 1'b0, 4'b0010);
    frame("R5 std frame to ext bank", 29'h1ABCDE12, 1'b0, 1'b0, 4'b0000);
    frame("R5 bit 28 differs", 29'h0ABCDE12, 1'b1, 1'b0, 4'b0000);
  endtask

  task automatic t_mask();
    wr(2, 0, 32'h0000_0000);
    wr(2, 1, 32'h2000_000F);       // low nibble and RTR don't-care
    wr(2, 2, 32'h1);
    frame("R6 masked bits differ", 29'h00A, 1'b0, 1'b1, 4'b0100);
    frame("R6 unmasked bit differs", 29'h010, 1'b0, 1'b0, 4'b0000);
    // R4: fully masked standard bank still rejects extended frames
    wr(2, 1, 32'h3FFF_FFFF);
    wr(2, 2, 32'h1);
    frame("R4 all-masked std vs ext", 29'h00A, 1'b1, 1'b0, 4'b0000);
    frame("R6 all-masked std any", 29'h7FF, 1'b0, 1'b1, 4'b0100);
  endtask

  task automatic t_multi();
    wr(3, 0, 32'h0);
    wr(3, 1, 32'h3FFF_FFFF);
    wr(3, 2, 32'h3);               // any extended frame
    frame("R7 two banks hit", 29'h1ABCDE12, 1'b1, 1'b0, 4'b1010);
    frame("R7 std two banks", 29'h123, 1'b0, 1'b0, 4'b0101);
  endtask

  task automatic t_reserved();
    wr(0, 3, 32'hFFFF_FFFF);
    frame("R9 reserved write no effect", 29'h123, 1'b0, 1'b0, 4'b0101);
  endtask

  task automatic t_update();
    wr(1, 0, 32'h0000_0055);
    frame("R8 bank1 disabled", 29'h1ABCDE12, 1'b1, 1'b0, 4'b1000);
    frame("R8 bank1 new code not live", 29'h55, 1'b1, 1'b0, 4'b1000);
    frame("R8 bank0 undisturbed", 29'h123, 1'b0, 1'b0, 4'b0101);
    wr(1, 2, 32'h3);
    frame("R8 bank1 after ctl", 29'h55, 1'b1, 1'b0, 4'b1010);
    wr(3, 1, 32'h3FFF_FFFF);       // mask write disables bank3
    frame("R8 mask write disables", 29'h55, 1'b1, 1'b0, 4'b0010);
    wr(3, 2, 32'h3);
  endtask

  task automatic t_same_cycle();
    frame("R10 write with strobe", 29'h123, 1'b0, 1'b0, 4'b0101,
          1, 0, 0, 32'h0000_07FF);
    frame("R10 bank0 now disabled", 29'h123, 1'b0, 1'b0, 4'b0100);
    frame("R10 new code not live", 29'h7FF, 1'b0, 1'b0, 4'b0100);
    wr(0, 2, 32'h1);
    frame("R10 new code live", 29'h7FF, 1'b0, 1'b0, 4'b0101);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    t_reset();
    t_std();
    t_ext();
    t_mask();
    t_multi();
    t_reserved();
    t_update();
    t_same_cycle();
    if (!finished) begin
      finished = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

  initial begin
    #(4 * 200000);
    if (!finished) begin
      finished = 1'b1;
      miscompares++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end
endmodule